// File: doc/BRIEF.md
# Two-Level Bounds Entry Walker

This block finds and moves the bounds record of one pointer. The caller gives the address where the pointer is stored. The walker first reads a directory word. Bits of the storage address select that word, counted from a directory base that stays fixed for the whole run of the program. A directory word with its valid flag clear is empty, and the walk stops there with a fault. A word with the flag set points to a second-level table. The walker then takes further bits of the storage address to pick a 32-byte record in that table.

A record holds a lower bound, an upper bound and the linear value of the pointer the bounds were made for.

- A **bounds load** reads the record. If the recorded pointer value still equals the caller's pointer, the stored bounds are returned. If it does not, the bounds no longer belong to this pointer, and full-range bounds are returned instead.
- A **bounds store** writes all three fields.

Memory is reached through a plain word-wide read/write port that has one access outstanding at a time. The walker handles one request at a time.

Top module: `bnd_walker`

## Requirements
- R1: `reqReady` is high only when the walker is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. While a walk is in progress, `reqReady` stays low.
- R2: The first memory access of every walk is a read (`memWe`=0) of the directory word. Its address is `dirBase + slotAddr[47:20]*8`.
- R3: A directory word with bit 0 clear ends the walk with `doneFault`=1. No further memory access is made, and `rspLower`, `rspUpper` and `rspPtr` are all zero.
- R4: For a directory word with bit 0 set, the table base is that word with bits [2:0] forced to zero. The record starts at `base + slotAddr[19:3]*32`.
- R5: A load reads the record words in this order, each at the given offset from the record start:
  - +0: lower bound
  - +8: upper bound
  - +16: recorded pointer value

  When the recorded pointer equals `reqPtr`, the load returns the lower bound, the upper bound and the recorded pointer, with `doneFault`=0.
- R6: When the recorded pointer differs from `reqPtr`, a load returns `rspLower`=0 and `rspUpper`=all ones. `rspPtr` still carries the recorded pointer value.
- R7: A store writes `reqLower` to +0, `reqUpper` to +8 and `reqPtr` to +16, in that order. It never touches the reserved word at +24. It finishes with `doneFault`=0 and all response fields zero.
- R8: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until the clock edge on which `memAck` is high.
- R9: `doneValid` is a one-cycle pulse at the end of each walk. `reqReady` is high in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 64 | Directory base byte address, fixed while running |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqIsStore | input | 1 | 1 = bounds store, 0 = bounds load |
| slotAddr | input | 64 | Address where the pointer itself is stored |
| reqPtr | input | 64 | Current pointer value |
| reqLower | input | 64 | Lower bound to store |
| reqUpper | input | 64 | Upper bound to store |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 64 | Memory byte address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Access completes on this edge |
| memRdata | input | 64 | Read data, valid with memAck |
| doneValid | output | 1 | Walk finished (one-cycle pulse) |
| doneFault | output | 1 | Directory entry was empty |
| rspLower | output | 64 | Returned lower bound |
| rspUpper | output | 64 | Returned upper bound |
| rspPtr | output | 64 | Returned recorded pointer |

## Verification
Suppose the state register or the beat counter goes wrong. The next memory access then shows it at once, as a wrong address, a wrong write flag, or a missing or extra access. This shows up within one access of the fault. A wrong mismatch or fault decision shows only in the response fields. These fields are sampled in the single cycle in which `doneValid` pulses. The bench therefore logs every access with its address and write flag, and compares the whole sequence and the response against values built from the request.

// File: rtl/bndw_pkg.sv
package bndw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } walkState_t;

  typedef struct packed {
    logic       capReq;   // latch request fields, clear captured words
    logic       capDir;   // latch table base from directory word
    logic       capWord;  // latch a record word (load)
    logic       selTbl;   // address the table instead of the directory
    logic [1:0] beat;     // record word index
    logic       loadOk;   // load finished without fault
  } ctlStrobes_t;

endpackage

// File: rtl/bndw_ctrl.sv
module bndw_ctrl
  import bndw_pkg::*;
#(
  parameter int REC_WORDS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsStore,
  output logic        reqReady,
  input  logic        memAck,
  input  logic        dirValid,
  output logic        memReq,
  output logic        memWe,
  output logic        doneValid,
  output logic        doneFault,
  output ctlStrobes_t strobes
);

  localparam logic [1:0] LAST_BEAT = 2'(REC_WORDS - 1);

  walkState_t state;
  logic [1:0] beat;
  logic       isStore;
  logic       faultR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beat    <= '0;
      isStore <= 1'b0;
      faultR  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_DIR;
          isStore <= reqIsStore;
          faultR  <= 1'b0;
          beat    <= '0;
        end
        ST_DIR: if (memAck) begin
          if (dirValid) state <= ST_TBL;
          else begin
            faultR <= 1'b1;
            state  <= ST_DONE;
          end
        end
        ST_TBL: if (memAck) begin
          if (beat == LAST_BEAT) state <= ST_DONE;
          else beat <= beat + 2'd1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady  = (state == ST_IDLE);
    memReq    = (state == ST_DIR) || (state == ST_TBL);
    memWe     = (state == ST_TBL) && isStore;
    doneValid = (state == ST_DONE);
    doneFault = (state == ST_DONE) && faultR;
    strobes.capReq  = (state == ST_IDLE) && reqValid;
    strobes.capDir  = (state == ST_DIR) && memAck && dirValid;
    strobes.capWord = (state == ST_TBL) && memAck && !isStore;
    strobes.selTbl  = (state == ST_TBL);
    strobes.beat    = beat;
    strobes.loadOk  = !isStore && !faultR;
  end

  // R1: no memory traffic and no completion while accepting
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReq && !doneValid));

  // R2: the directory access is always a read
  p_dir_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIR) |-> (memReq && !memWe));

  // R3: a faulted walk ends straight after the directory access
  p_fault_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneFault |-> ($past(state) == ST_DIR));

  // R7: writes happen only for stores
  p_we_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (isStore && strobes.selTbl));

  // R9: single-cycle completion, then idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

endmodule

// File: rtl/bndw_dpath.sv
module bndw_dpath
  import bndw_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 64,
  parameter int DIR_HI  = 47,
  parameter int DIR_LO  = 20,
  parameter int TBL_LO  = 3,
  parameter int DENT_SH = 3,
  parameter int TREC_SH = 5,
  parameter int WORD_SH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic [DATA_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqLower,
  input  logic [DATA_W-1:0] reqUpper,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspLower,
  output logic [DATA_W-1:0] rspUpper,
  output logic [DATA_W-1:0] rspPtr
);

  localparam int DIR_W = DIR_HI - DIR_LO + 1;
  localparam int TBL_W = DIR_LO - TBL_LO;
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << DENT_SH) - ADDR_W'(1));

  logic [ADDR_W-1:0] slotR, tblBase;
  logic [DATA_W-1:0] ptrR, lowInR, upInR;
  logic [DATA_W-1:0] recWord [3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotR   <= '0;
      ptrR    <= '0;
      lowInR  <= '0;
      upInR   <= '0;
      tblBase <= '0;
      for (int i = 0; i < 3; i++) recWord[i] <= '0;
    end else begin
      if (strobes.capReq) begin
        slotR  <= slotAddr;
        ptrR   <= reqPtr;
        lowInR <= reqLower;
        upInR  <= reqUpper;
        for (int i = 0; i < 3; i++) recWord[i] <= '0;
      end
      if (strobes.capDir) tblBase <= memRdata[ADDR_W-1:0] & BASE_MASK;
      if (strobes.capWord && strobes.beat < 2'd3) recWord[strobes.beat] <= memRdata;
    end
  end

  logic [DIR_W-1:0]  dirIdx;
  logic [TBL_W-1:0]  tblIdx;
  logic [ADDR_W-1:0] dirOff, recOff, wordOff;

  always_comb begin
    dirIdx  = slotR[DIR_HI:DIR_LO];
    tblIdx  = slotR[DIR_LO-1:TBL_LO];
    dirOff  = ADDR_W'(dirIdx) << DENT_SH;
    recOff  = ADDR_W'(tblIdx) << TREC_SH;
    wordOff = ADDR_W'(strobes.beat) << WORD_SH;
    memAddr = strobes.selTbl ? (tblBase + recOff + wordOff) : (dirBase + dirOff);
    unique case (strobes.beat)
      2'd0:    memWdata = lowInR;
      2'd1:    memWdata = upInR;
      default: memWdata = ptrR;
    endcase
  end

  logic ptrMatch;
  always_comb begin
    ptrMatch = (recWord[2] == ptrR);
    if (!strobes.loadOk) begin
      rspLower = '0;
      rspUpper = '0;
      rspPtr   = '0;
    end else if (ptrMatch) begin
      rspLower = recWord[0];
      rspUpper = recWord[1];
      rspPtr   = recWord[2];
    end else begin
      rspLower = '0;
      rspUpper = '1;
      rspPtr   = recWord[2];
    end
  end

  // R4: table accesses stay word-aligned inside the selected record
  p_tbl_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selTbl |-> (memAddr[WORD_SH-1:0] == '0));

endmodule

// File: rtl/bnd_walker.sv
module bnd_walker
  import bndw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int DIR_HI = 47,
  parameter int DIR_LO = 20,
  parameter int TBL_LO = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsStore,
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic [DATA_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqLower,
  input  logic [DATA_W-1:0] reqUpper,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              doneValid,
  output logic              doneFault,
  output logic [DATA_W-1:0] rspLower,
  output logic [DATA_W-1:0] rspUpper,
  output logic [DATA_W-1:0] rspPtr
);

  ctlStrobes_t strobes;

  bndw_ctrl #(.REC_WORDS(3)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsStore(reqIsStore), .reqReady(reqReady),
    .memAck(memAck), .dirValid(memRdata[0]),
    .memReq(memReq), .memWe(memWe),
    .doneValid(doneValid), .doneFault(doneFault),
    .strobes(strobes)
  );

  bndw_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIR_HI(DIR_HI), .DIR_LO(DIR_LO), .TBL_LO(TBL_LO)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dirBase(dirBase), .slotAddr(slotAddr),
    .reqPtr(reqPtr), .reqLower(reqLower), .reqUpper(reqUpper),
    .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .rspLower(rspLower), .rspUpper(rspUpper), .rspPtr(rspPtr)
  );

  // R8: a pending access keeps its command stable until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && $stable(memWdata)));

endmodule

// File: tb/bnd_walker_tb.sv
module bnd_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] dirBase = 64'h0000_1000_0000_0000;
  logic        reqValid = 1'b0, reqIsStore = 1'b0;
  logic [63:0] slotAddr = '0, reqPtr = '0, reqLower = '0, reqUpper = '0;
  logic        reqReady, memReq, memWe, memAck, doneValid, doneFault;
  logic [63:0] memAddr, memWdata, memRdata, rspLower, rspUpper, rspPtr;

  always #2 clk = ~clk;  // 250 MHz

  bnd_walker dut_i (
    .clk(clk), .rstN(rstN), .dirBase(dirBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqIsStore(reqIsStore),
    .slotAddr(slotAddr), .reqPtr(reqPtr), .reqLower(reqLower), .reqUpper(reqUpper),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .doneValid(doneValid), .doneFault(doneFault),
    .rspLower(rspLower), .rspUpper(rspUpper), .rspPtr(rspPtr)
  );

  int total = 0, bad = 0;

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [63:0]];
  logic [63:0] logAddr [$];
  logic        logWe [$];
  int          lat = 0, waitCnt = 0, holdViol = 0;
  logic [63:0] heldAddr;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memRdata <= '0; waitCnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0; waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt == 0) heldAddr <= memAddr;
      else if (memAddr !== heldAddr) holdViol <= holdViol + 1;
      if (waitCnt >= lat) begin
        memAck <= 1'b1;
        logAddr.push_back(memAddr);
        logWe.push_back(memWe);
        if (memWe) mem[memAddr] = memWdata;
        else memRdata <= rd(memAddr);
      end else waitCnt <= waitCnt + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dirAddrOf(input logic [63:0] s);
    return dirBase + ({36'b0, s[47:20]} << 3);
  endfunction

  function automatic logic [63:0] recAddrOf(input logic [63:0] base, input logic [63:0] s);
    return (base & ~64'h7) + ({47'b0, s[19:3]} << 5);
  endfunction

  logic [63:0] gotLo, gotUp, gotPtr;
  logic        gotFault;
  int          busyReadyHigh;

  task automatic runOp(input logic st, input logic [63:0] sa, input logic [63:0] p,
                       input logic [63:0] lo, input logic [63:0] up);
    int cyc = 0;
    logAddr.delete(); logWe.delete();
    busyReadyHigh = 0;
    @(negedge clk);
    reqValid = 1'b1; reqIsStore = st; slotAddr = sa; reqPtr = p;
    reqLower = lo; reqUpper = up;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid && cyc < 2000) begin
      if (reqReady) busyReadyHigh++;
      @(negedge clk); cyc++;
    end
    if (cyc >= 2000) begin
      total++; bad++;
      $display("FAIL R9: watchdog actual=no-done expected=done");
    end
    gotLo = rspLower; gotUp = rspUpper; gotPtr = rspPtr; gotFault = doneFault;
    @(negedge clk);
    chk("R9 pulse low after done", {63'b0, doneValid}, 64'd0);
    chk("R9 ready after done", {63'b0, reqReady}, 64'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    chk("R1 reset ready", {63'b0, reqReady}, 64'd1);
    chk("R8 reset memReq", {63'b0, memReq}, 64'd0);
    chk("R9 reset done", {63'b0, doneValid}, 64'd0);
  endtask

  task automatic tLoadMatch();
    logic [63:0] sa = 64'h0000_1234_5678_9ab8;
    logic [63:0] tb = 64'h0000_2000_0000_0000;
    logic [63:0] ra = recAddrOf(tb, sa);
    mem[dirAddrOf(sa)] = tb | 64'h1;
    mem[ra] = 64'h1000; mem[ra+8] = 64'h1fff; mem[ra+16] = 64'hcafe_0000_1234;
    lat = 0;
    runOp(1'b0, sa, 64'hcafe_0000_1234, '0, '0);
    chk("R1 ready low while busy", busyReadyHigh, 0);
    chk("R2 first access addr", logAddr[0], dirAddrOf(sa));
    chk("R2 first access read", {63'b0, logWe[0]}, 64'd0);
    chk("R5 access count", logAddr.size(), 4);
    chk("R4 word0 addr", logAddr[1], ra);
    chk("R5 word1 addr", logAddr[2], ra + 8);
    chk("R5 word2 addr", logAddr[3], ra + 16);
    chk("R5 lower", gotLo, 64'h1000);
    chk("R5 upper", gotUp, 64'h1fff);
    chk("R5 ptr", gotPtr, 64'hcafe_0000_1234);
    chk("R5 no fault", {63'b0, gotFault}, 64'd0);
  endtask

  task automatic tLoadMismatch();
    logic [63:0] sa = 64'h0000_0000_0030_0010;
    logic [63:0] tb = 64'h0000_3000_0000_0040;
    logic [63:0] ra = recAddrOf(tb, sa);
    mem[dirAddrOf(sa)] = tb | 64'h7;  // R4: low bits must be dropped
    mem[ra] = 64'h500; mem[ra+8] = 64'h5ff; mem[ra+16] = 64'h7777;
    lat = 3;
    runOp(1'b0, sa, 64'h8888, '0, '0);
    chk("R4 masked base addr", logAddr[1], ra);
    chk("R6 lower zero", gotLo, 64'h0);
    chk("R6 upper ones", gotUp, 64'hffff_ffff_ffff_ffff);
    chk("R6 ptr recorded", gotPtr, 64'h7777);
    chk("R6 no fault", {63'b0, gotFault}, 64'd0);
    chk("R8 hold while waiting", holdViol, 0);
  endtask

  task automatic tFault();
    logic [63:0] sa = 64'h0000_7fff_fff0_0008;
    mem[dirAddrOf(sa)] = 64'h0000_4000_0000_0000;  // bit0 clear -> empty
    lat = 1;
    runOp(1'b0, sa, 64'h1, '0, '0);
    chk("R3 fault flag", {63'b0, gotFault}, 64'd1);
    chk("R3 single access", logAddr.size(), 1);
    chk("R3 dir addr", logAddr[0], dirAddrOf(sa));
    chk("R3 lower zero", gotLo, 64'h0);
    chk("R3 upper zero", gotUp, 64'h0);
    chk("R3 ptr zero", gotPtr, 64'h0);
  endtask

  task automatic tStoreThenLoad();
    logic [63:0] sa = 64'h0000_0abc_def0_1238;
    logic [63:0] tb = 64'h0000_5000_0000_0000;
    logic [63:0] ra = recAddrOf(tb, sa);
    mem[dirAddrOf(sa)] = tb | 64'h1;
    mem[ra+24] = 64'hdead_beef;
    lat = 2;
    runOp(1'b1, sa, 64'h4242, 64'h4000, 64'h40ff);
    chk("R7 access count", logAddr.size(), 4);
    chk("R7 dir read", {63'b0, logWe[0]}, 64'd0);
    chk("R7 w0 write", {63'b0, logWe[1]}, 64'd1);
    chk("R7 w0 addr", logAddr[1], ra);
    chk("R7 w1 addr", logAddr[2], ra + 8);
    chk("R7 w2 addr", logAddr[3], ra + 16);
    chk("R7 lower stored", rd(ra), 64'h4000);
    chk("R7 upper stored", rd(ra + 8), 64'h40ff);
    chk("R7 ptr stored", rd(ra + 16), 64'h4242);
    chk("R7 reserved untouched", rd(ra + 24), 64'hdead_beef);
    chk("R7 resp zero", gotLo | gotUp | gotPtr, 64'h0);
    chk("R7 no fault", {63'b0, gotFault}, 64'd0);
    lat = 0;
    runOp(1'b0, sa, 64'h4242, '0, '0);
    chk("R5 reload lower", gotLo, 64'h4000);
    chk("R5 reload upper", gotUp, 64'h40ff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLoadMatch();
    tLoadMismatch();
    tFault();
    tStoreThenLoad();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL R9: global watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule